// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides whether a phase-locked loop has settled. Once per phase-detector cycle an upstream measurement stage presents the skew between the up and down pulses as an unsigned integer count of nanoseconds, together with a one-cycle valid strobe. The detector counts consecutive samples whose skew falls inside a lock window. When the run reaches the number of samples required by the current mode, it raises its lock flag.

Once locked, the flag drops only when a sample exceeds a wider unlock threshold. Skews between the window and that threshold therefore leave lock untouched, which gives hysteresis. Three static mode inputs select the window and the required run. One chooses integer or fractional loop operation. One chooses fast or slow detection. One chooses coarse or fine precision. A synchronous clear input restarts detection from scratch.

Top module: `lockdet_top`

## Requirements
- R1: During and after reset `locked` is 0 and the run of counted samples is empty.
- R2: With `mode_fast`=0 and `mode_fine`=0, a valid sample counts toward lock when `skew_ns` <= 10; a sample at 11 does not.
- R3: With `mode_fast`=0 and `mode_fine`=1, the lock window is `skew_ns` <= 6.
- R4: With `mode_fast`=1, the lock window is `skew_ns` <= 4, whatever the value of `mode_fine`.
- R5: With `mode_int`=0 (fractional), `locked` rises on the clock edge that takes the 40th consecutive in-window valid sample, and not before.
- R6: With `mode_int`=1 (integer), `locked` rises on the clock edge that takes the 5th consecutive in-window valid sample.
- R7: While locked, a valid sample with `skew_ns` above 15 (`mode_fast`=0) or above 4 (`mode_fast`=1) clears `locked` at that edge and empties the run.
- R8: Before lock, any valid sample outside the lock window restarts the run at zero, so a full new run is needed.
- R9: While locked, valid samples whose skew is outside the lock window but at or below the unlock threshold keep `locked` at 1.
- R10: `clear` high at a clock edge sets `locked` to 0 and empties the run, taking priority over any sample at that edge.
- R11: Clock edges with `sample_valid`=0 change neither `locked` nor the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | One skew sample is presented this cycle |
| skew_ns | input | SKEW_W (8) | Measured up/down skew in ns, unsigned |
| mode_int | input | 1 | 1 = integer loop, 0 = fractional loop |
| mode_fast | input | 1 | 1 = fast detection (4 ns window and threshold) |
| mode_fine | input | 1 | 1 = fine window when slow (6 ns instead of 10 ns) |
| clear | input | 1 | Synchronous restart of the detector |
| locked | output | 1 | Lock indication |

## Verification
On every cycle, the assertions check these behaviours:
- the priority of clear;
- that idle cycles leave the flag alone;
- that lock can only rise on a valid, non-cleared sample;
- that a sample past the unlock threshold drops lock, while one at or below the threshold keeps it;
- that an out-of-window sample empties the run.

Only the bench's scenarios can show the exact window edges and run lengths for each of the eight mode combinations. The bench sweeps the skew across the hysteresis band and walks runs up to one short of and exactly at the required count. It also confirms that the fine setting has no effect in fast mode.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

    typedef enum logic {
        ST_SEEK = 1'b0,
        ST_HELD = 1'b1
    } lock_state_e;

    typedef struct packed {
        logic integer_mode;
        logic fast;
        logic fine;
    } lock_mode_t;

    function automatic int unsigned pick_window(lock_mode_t m, int unsigned wide,
                                                int unsigned narrow, int unsigned fastw);
        if (m.fast)      return fastw;
        else if (m.fine) return narrow;
        else             return wide;
    endfunction

    function automatic int unsigned pick_drop(lock_mode_t m, int unsigned slow_lim,
                                              int unsigned fast_lim);
        return m.fast ? fast_lim : slow_lim;
    endfunction

    function automatic int unsigned pick_run(lock_mode_t m, int unsigned frac_run,
                                             int unsigned int_run);
        return m.integer_mode ? int_run : frac_run;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lockdet_window.sv
module lockdet_window
    import lockdet_pkg::*;
#(
    parameter int SKEW_W     = 8,
    parameter int CNT_W      = 6,
    parameter int WIN_WIDE   = 10,
    parameter int WIN_NARROW = 6,
    parameter int WIN_FAST   = 4,
    parameter int DROP_SLOW  = 15,
    parameter int DROP_FAST  = 4,
    parameter int RUN_FRAC   = 40,
    parameter int RUN_INT    = 5
) (
    input  lock_mode_t        mode,
    input  logic [SKEW_W-1:0] skew,
    output logic              in_window,
    output logic              past_drop,
    output logic [CNT_W-1:0]  run_needed
);
    logic [SKEW_W-1:0] win_lim;
    logic [SKEW_W-1:0] drop_lim;

    always_comb begin
        win_lim    = SKEW_W'(pick_window(mode, WIN_WIDE, WIN_NARROW, WIN_FAST));
        drop_lim   = SKEW_W'(pick_drop(mode, DROP_SLOW, DROP_FAST));
        run_needed = CNT_W'(pick_run(mode, RUN_FRAC, RUN_INT));
        in_window  = (skew <= win_lim);
        past_drop  = (skew > drop_lim);
    end

    // R4: fast mode makes the fine bit irrelevant
    always_comb begin
        if (mode.fast) begin
            assert_fast_ignores_fine_R4: assert (in_window == (skew <= SKEW_W'(WIN_FAST)));
        end
    end
endmodule

// File: rtl/lockdet_run_counter.sv
module lockdet_run_counter #(
    parameter int CNT_W   = 6,
    parameter int CNT_MAX = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            count <= '0;
        end else if (advance && count != SAT) begin
            count <= count + 1'b1;
        end
    end

    assert_never_past_max_R8: assert property (@(posedge clk) disable iff (rst)
        count <= SAT);
endmodule

// File: rtl/lockdet_top.sv
module lockdet_top
    import lockdet_pkg::*;
#(
    parameter int SKEW_W     = 8,
    parameter int WIN_WIDE   = 10,
    parameter int WIN_NARROW = 6,
    parameter int WIN_FAST   = 4,
    parameter int DROP_SLOW  = 15,
    parameter int DROP_FAST  = 4,
    parameter int RUN_FRAC   = 40,
    parameter int RUN_INT    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_valid,
    input  logic [SKEW_W-1:0] skew_ns,
    input  logic              mode_int,
    input  logic              mode_fast,
    input  logic              mode_fine,
    input  logic              clear,
    output logic              locked
);
    localparam int CNT_MAX = int'(max2(RUN_FRAC, RUN_INT));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    lock_mode_t       mode;
    lock_state_e      state;
    logic             in_window;
    logic             past_drop;
    logic [CNT_W-1:0] run_needed;
    logic [CNT_W-1:0] run_count;
    logic             run_done;
    logic             advance;
    logic             restart;

    assign mode = '{integer_mode: mode_int, fast: mode_fast, fine: mode_fine};

    lockdet_window #(
        .SKEW_W(SKEW_W), .CNT_W(CNT_W),
        .WIN_WIDE(WIN_WIDE), .WIN_NARROW(WIN_NARROW), .WIN_FAST(WIN_FAST),
        .DROP_SLOW(DROP_SLOW), .DROP_FAST(DROP_FAST),
        .RUN_FRAC(RUN_FRAC), .RUN_INT(RUN_INT)
    ) window_i (
        .mode(mode), .skew(skew_ns),
        .in_window(in_window), .past_drop(past_drop), .run_needed(run_needed)
    );

    always_comb begin
        run_done = in_window &&
                   (({1'b0, run_count} + 1'b1) >= {1'b0, run_needed});
        advance  = sample_valid && in_window && !clear;
        restart  = clear ||
                   (sample_valid && (!in_window || (state == ST_HELD && past_drop)));
    end

    lockdet_run_counter #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) counter_i (
        .clk(clk), .rst(rst), .advance(advance), .restart(restart), .count(run_count)
    );

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state <= ST_SEEK;
        end else if (sample_valid) begin
            case (state)
                ST_SEEK: if (run_done)  state <= ST_HELD;
                ST_HELD: if (past_drop) state <= ST_SEEK;
                default: state <= ST_SEEK;
            endcase
        end
    end

    assign locked = (state == ST_HELD);

    assert_rise_needs_sample_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(sample_valid && !clear));

    assert_drop_on_big_skew_R7: assert property (@(posedge clk) disable iff (rst)
        (locked && sample_valid && !clear && past_drop) |=> !locked);

    assert_out_of_window_restarts_R8: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && !in_window) |=> (run_count == '0));

    assert_hold_in_band_R9: assert property (@(posedge clk) disable iff (rst)
        (locked && sample_valid && !clear && !past_drop) |=> locked);

    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!locked && run_count == '0));

    assert_idle_keeps_state_R11: assert property (@(posedge clk) disable iff (rst)
        (!sample_valid && !clear) |=> ($stable(locked) && $stable(run_count)));
endmodule

// File: tb/lockdet_top_tb_top.sv
`timescale 1ns/1ps
module lockdet_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_valid = 1'b0;
    logic [7:0] skew_ns = '0;
    logic       mode_int = 1'b0;
    logic       mode_fast = 1'b0;
    logic       mode_fine = 1'b0;
    logic       clear = 1'b0;
    logic       locked;

    int checks = 0;
    int fails  = 0;
    int exp_cnt = 0;
    bit exp_lock = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lockdet_top dut_i (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .skew_ns(skew_ns),
        .mode_int(mode_int), .mode_fast(mode_fast), .mode_fine(mode_fine),
        .clear(clear), .locked(locked)
    );

    function automatic int win_of();
        if (mode_fast) return 4;
        return mode_fine ? 6 : 10;
    endfunction
    function automatic int drop_of();
        return mode_fast ? 4 : 15;
    endfunction
    function automatic int need_of();
        return mode_int ? 5 : 40;
    endfunction

    task automatic check(string tag);
        checks++;
        if (locked !== exp_lock) begin
            fails++;
            $display("FAIL %s: locked=%0b expected=%0b (skew=%0d int=%0b fast=%0b fine=%0b)",
                     tag, locked, exp_lock, skew_ns, mode_int, mode_fast, mode_fine);
        end
    endtask

    // one clock step with the reference model from the requirements
    task automatic step(bit v, int s, bit c, string tag);
        sample_valid = v;
        skew_ns = 8'(s);
        clear = c;
        @(posedge clk);
        if (c) begin
            exp_lock = 0; exp_cnt = 0;
        end else if (v) begin
            if (!exp_lock) begin
                if (s <= win_of()) begin
                    exp_cnt++;
                    if (exp_cnt >= need_of()) exp_lock = 1;
                end else exp_cnt = 0;
            end else if (s > drop_of()) begin
                exp_lock = 0; exp_cnt = 0;
            end else begin
                exp_cnt = (s <= win_of()) ? exp_cnt + 1 : 0;
            end
        end
        @(negedge clk);
        sample_valid = 0;
        clear = 0;
        check(tag);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        string wtag, ntag;
        repeat (3) @(negedge clk);
        check("R1");
        rst = 0;
        step(0, 0, 0, "R1");
        for (int m = 0; m < 8; m++) begin
            mode_int  = m[2];
            mode_fast = m[1];
            mode_fine = m[0];
            wtag = mode_fast ? "R4" : (mode_fine ? "R3" : "R2");
            ntag = mode_int ? "R6" : "R5";
            step(0, 0, 1, "R10");
            // run one short, break it, rebuild to exact count
            for (int i = 0; i < need_of() - 1; i++) step(1, win_of(), 0, ntag);
            step(1, win_of() + 1, 0, "R8");
            for (int i = 0; i < need_of() - 1; i++) step(1, win_of(), 0, "R8");
            step(1, win_of(), 0, ntag);
            // sweep the band up to and across the unlock threshold
            for (int s = 0; s <= drop_of(); s++) step(1, s, 0, "R9");
            step(1, drop_of() + 1, 0, "R7");
            // relock, then idle with a wild skew
            for (int i = 0; i < need_of(); i++) step(1, 0, 0, ntag);
            step(0, 255, 0, "R11");
            step(1, 255, 1, "R10");
            for (int i = 0; i < need_of() - 1; i++) step(1, win_of(), 0, "R10");
            step(0, 255, 0, "R11");
            step(1, win_of(), 0, "R10");
            // just outside the window never locks
            step(0, 0, 1, "R10");
            for (int i = 0; i < need_of() + 2; i++) step(1, win_of() + 1, 0, wtag);
            for (int i = 0; i < need_of(); i++) step(1, win_of(), 0, wtag);
        end
        // reset clears a held lock
        rst = 1;
        @(posedge clk);
        exp_lock = 0; exp_cnt = 0;
        @(negedge clk);
        check("R1");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule